// File: doc/BRIEF.md
# Commit Thread Selector for Multithreaded Retirement

In a core that runs several hardware threads, each thread keeps its own reorder-buffer head. Each commit slot, this block chooses which thread may retire its head instruction. For every thread it receives a 3-bit commit state, a flag that the thread's reorder buffer is empty, a flag that its head instruction is ready, and the head's sequence number. A 2-bit policy input chooses how competing threads are arbitrated. The block reports a valid flag and the index of the chosen thread.

The choice is purely combinational from the inputs. The only stored state is the rotating priority order used in round-robin mode. That order advances only when the consumer signals that it used the grant. A thread count of one is a separate build variant that needs no arbitration.

Top module: `commit_thread_pick`

## Requirements
- R1: A thread may be chosen only when its state code is running (0), idle (1) or fetch-trap-waiting (4). Squashing (2), trap-waiting (3) and the unused codes 5 to 7 never win.
- R2: With more than one thread, a thread also needs an empty flag of 0 and a ready flag of 1 to be eligible.
- R3: In round-robin mode (policy 1), the winner is the first eligible thread in the stored priority order.
- R4: On a clock edge where the grant-used input is 1 and a round-robin selection is valid, the winner moves to the tail of the order, and the entries behind it move up one place. Without a grant, or in any other policy, the order is kept.
- R5: In oldest mode (policy 2), the winner is the eligible thread whose head has the smallest unsigned 32-bit sequence number. On a tie, the lowest thread index wins.
- R6: Aggressive mode (policy 0) makes the same choice as oldest mode.
- R7: When no thread qualifies, the valid output is 0 and the index output is 0.
- R8: After reset, the round-robin order is ascending by thread index.
- R9: In the single-thread variant, policy, empty flag and ready flag are ignored. Thread 0 is reported valid exactly when its state code satisfies R1.
- R10: Policy code 3 disables selection: the valid output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| policy_i | input | 2 | 0 aggressive, 1 round-robin, 2 oldest, 3 off |
| thr_state_i | input | 3*NUM_THREADS | Per-thread commit state codes, thread 0 in the low bits |
| rob_empty_i | input | NUM_THREADS | Per-thread reorder buffer empty |
| head_ready_i | input | NUM_THREADS | Per-thread head instruction ready |
| head_seq_i | input | SEQ_W*NUM_THREADS | Per-thread head sequence numbers |
| grant_used_i | input | 1 | The current selection was consumed this cycle |
| sel_valid_o | output | 1 | A thread is selected |
| sel_tid_o | output | TID_W | Index of the selected thread |

## Verification
The hardest case to reach from the ports is a round-robin order that has been rotated into an arbitrary permutation. The only way to get there is a long series of consumed grants, each made while a different subset of threads is eligible. The bench drives thousands of steps with pseudo-random states, flags, policies and grant pulses, and keeps its own model of the order, so that the order drifts through many permutations. Sequence numbers are drawn from a narrow range, which makes ties in oldest mode frequent.

// File: rtl/cmt_pick_pkg.sv
package cmt_pick_pkg;
   localparam logic [2:0] ST_RUN        = 3'd0;
   localparam logic [2:0] ST_IDLE       = 3'd1;
   localparam logic [2:0] ST_SQUASH     = 3'd2;
   localparam logic [2:0] ST_TRAP_WAIT  = 3'd3;
   localparam logic [2:0] ST_FETCH_TRAP = 3'd4;

   localparam logic [1:0] POL_AGGR   = 2'd0;
   localparam logic [1:0] POL_RR     = 2'd1;
   localparam logic [1:0] POL_OLDEST = 2'd2;
   localparam logic [1:0] POL_OFF    = 2'd3;

   localparam int ST_W = 3;

   function automatic logic state_commits(input logic [2:0] s);
      return (s == ST_RUN) || (s == ST_IDLE) || (s == ST_FETCH_TRAP);
   endfunction
endpackage

// File: rtl/cmt_elig.sv
module cmt_elig
   import cmt_pick_pkg::*;
#(
   parameter int NUM_THREADS = 4
) (
   input  logic [NUM_THREADS*ST_W-1:0] thr_state_i,
   input  logic [NUM_THREADS-1:0]      rob_empty_i,
   input  logic [NUM_THREADS-1:0]      head_ready_i,
   output logic [NUM_THREADS-1:0]      state_ok_o,
   output logic [NUM_THREADS-1:0]      elig_o
);
   for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
      assign state_ok_o[t] = state_commits(thr_state_i[t*ST_W +: ST_W]);
      assign elig_o[t]     = state_ok_o[t] & ~rob_empty_i[t] & head_ready_i[t];
   end
endmodule

// File: rtl/cmt_oldest.sv
module cmt_oldest #(
   parameter int NUM_THREADS = 4,
   parameter int SEQ_W       = 32,
   parameter int TID_W       = 2
) (
   input  logic [NUM_THREADS-1:0]       elig_i,
   input  logic [NUM_THREADS*SEQ_W-1:0] seq_i,
   output logic                         found_o,
   output logic [TID_W-1:0]             tid_o
);
   logic [SEQ_W-1:0] best;

   always_comb begin
      found_o = 1'b0;
      tid_o   = '0;
      best    = '1;
      for (int i = 0; i < NUM_THREADS; i++) begin
         if (elig_i[i] && (!found_o || (seq_i[i*SEQ_W +: SEQ_W] < best))) begin
            found_o = 1'b1;
            best    = seq_i[i*SEQ_W +: SEQ_W];
            tid_o   = TID_W'(i);
         end
      end
   end
endmodule

// File: rtl/cmt_rr_list.sv
module cmt_rr_list #(
   parameter int NUM_THREADS = 4,
   parameter int TID_W       = 2
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [NUM_THREADS-1:0] elig_i,
   input  logic                   advance_i,
   output logic                   found_o,
   output logic [TID_W-1:0]       tid_o
);
   localparam int ORD_W = NUM_THREADS * TID_W;

   logic [ORD_W-1:0] order_q;
   logic [ORD_W-1:0] order_d;
   int               win_pos;

   always_comb begin
      found_o = 1'b0;
      tid_o   = '0;
      win_pos = 0;
      for (int p = 0; p < NUM_THREADS; p++) begin
         if (!found_o && elig_i[order_q[p*TID_W +: TID_W]]) begin
            found_o = 1'b1;
            tid_o   = order_q[p*TID_W +: TID_W];
            win_pos = p;
         end
      end
   end

   always_comb begin
      order_d = order_q;
      if (advance_i && found_o) begin
         for (int i = 0; i < NUM_THREADS - 1; i++) begin
            if (i >= win_pos) order_d[i*TID_W +: TID_W] = order_q[(i+1)*TID_W +: TID_W];
         end
         order_d[(NUM_THREADS-1)*TID_W +: TID_W] = tid_o;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < NUM_THREADS; i++) order_q[i*TID_W +: TID_W] <= TID_W'(i);
      end else begin
         order_q <= order_d;
      end
   end

   // Order must stay a permutation of the thread indices
   always @(posedge clk) begin
      if (rst_n) begin
         for (int t = 0; t < NUM_THREADS; t++) begin
            int hits;
            hits = 0;
            for (int p = 0; p < NUM_THREADS; p++)
               if (order_q[p*TID_W +: TID_W] == TID_W'(t)) hits++;
            p_perm_r4: assert (hits == 1) else $error("order lost thread %0d", t);
         end
      end
   end

   p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !(advance_i && found_o) |=> $stable(order_q));
   p_tail_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (advance_i && found_o) |=> order_q[(NUM_THREADS-1)*TID_W +: TID_W] == $past(tid_o));
endmodule

// File: rtl/commit_thread_pick.sv
module commit_thread_pick
   import cmt_pick_pkg::*;
#(
   parameter int NUM_THREADS = 4,
   parameter int SEQ_W       = 32,
   parameter int TID_W       = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [1:0]                   policy_i,
   input  logic [NUM_THREADS*ST_W-1:0]  thr_state_i,
   input  logic [NUM_THREADS-1:0]       rob_empty_i,
   input  logic [NUM_THREADS-1:0]       head_ready_i,
   input  logic [NUM_THREADS*SEQ_W-1:0] head_seq_i,
   input  logic                         grant_used_i,
   output logic                         sel_valid_o,
   output logic [TID_W-1:0]             sel_tid_o
);
   if (NUM_THREADS < 1 || NUM_THREADS > 8) begin : g_bad_cnt
      $error("NUM_THREADS must be 1..8");
   end
   if (SEQ_W < 1) begin : g_bad_seq
      $error("SEQ_W must be positive");
   end

   logic [NUM_THREADS-1:0] state_ok;
   logic [NUM_THREADS-1:0] elig;

   cmt_elig #(.NUM_THREADS(NUM_THREADS)) u_elig (
      .thr_state_i (thr_state_i),
      .rob_empty_i (rob_empty_i),
      .head_ready_i(head_ready_i),
      .state_ok_o  (state_ok),
      .elig_o      (elig)
   );

   if (NUM_THREADS == 1) begin : g_single
      assign sel_valid_o = state_ok[0];
      assign sel_tid_o   = '0;

      p_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
         sel_valid_o == state_commits(thr_state_i[ST_W-1:0]));
   end else begin : g_multi
      logic             old_found, rr_found;
      logic [TID_W-1:0] old_tid, rr_tid;
      logic             rr_mode;

      assign rr_mode = (policy_i == POL_RR);

      cmt_oldest #(.NUM_THREADS(NUM_THREADS), .SEQ_W(SEQ_W), .TID_W(TID_W)) u_oldest (
         .elig_i (elig),
         .seq_i  (head_seq_i),
         .found_o(old_found),
         .tid_o  (old_tid)
      );

      cmt_rr_list #(.NUM_THREADS(NUM_THREADS), .TID_W(TID_W)) u_rr (
         .clk      (clk),
         .rst_n    (rst_n),
         .elig_i   (elig),
         .advance_i(grant_used_i && rr_mode),
         .found_o  (rr_found),
         .tid_o    (rr_tid)
      );

      always_comb begin
         sel_valid_o = 1'b0;
         sel_tid_o   = '0;
         unique case (policy_i)
            POL_AGGR, POL_OLDEST: begin
               sel_valid_o = old_found;
               sel_tid_o   = old_found ? old_tid : '0;
            end
            POL_RR: begin
               sel_valid_o = rr_found;
               sel_tid_o   = rr_found ? rr_tid : '0;
            end
            default: begin
               sel_valid_o = 1'b0;
               sel_tid_o   = '0;
            end
         endcase
      end

      p_state_ok_r1: assert property (@(posedge clk) disable iff (!rst_n)
         sel_valid_o |-> state_commits(thr_state_i[sel_tid_o*ST_W +: ST_W]));
      p_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
         sel_valid_o |-> (!rob_empty_i[sel_tid_o] && head_ready_i[sel_tid_o]));
      p_none_r7: assert property (@(posedge clk) disable iff (!rst_n)
         (elig == '0) |-> (!sel_valid_o && sel_tid_o == '0));
      p_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
         (policy_i == POL_OFF) |-> !sel_valid_o);

      // Oldest and aggressive modes: no eligible thread may be strictly older
      always @(posedge clk) begin
         if (rst_n && sel_valid_o && (policy_i == POL_OLDEST || policy_i == POL_AGGR)) begin
            for (int t = 0; t < NUM_THREADS; t++) begin
               p_oldest_r5: assert (!elig[t] ||
                  head_seq_i[t*SEQ_W +: SEQ_W] > head_seq_i[sel_tid_o*SEQ_W +: SEQ_W] ||
                  (head_seq_i[t*SEQ_W +: SEQ_W] == head_seq_i[sel_tid_o*SEQ_W +: SEQ_W] &&
                   TID_W'(t) >= sel_tid_o))
                  else $error("older eligible thread %0d skipped", t);
            end
         end
      end
   end
endmodule

// File: tb/tb_commit_thread_pick.sv
`timescale 1ns/1ps
module tb_commit_thread_pick;
   localparam int NT = 4;
   localparam int SW = 32;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   logic [1:0]       policy;
   logic [NT*3-1:0]  st;
   logic [NT-1:0]    emp, rdy;
   logic [NT*SW-1:0] seq;
   logic             grant;
   logic             vld;
   logic [1:0]       tid;

   logic [2:0] st1;
   logic       emp1, rdy1, vld1;
   logic [0:0] tid1;

   commit_thread_pick #(.NUM_THREADS(NT), .SEQ_W(SW)) dut (
      .clk(clk), .rst_n(rst_n), .policy_i(policy), .thr_state_i(st),
      .rob_empty_i(emp), .head_ready_i(rdy), .head_seq_i(seq),
      .grant_used_i(grant), .sel_valid_o(vld), .sel_tid_o(tid));

   commit_thread_pick #(.NUM_THREADS(1), .SEQ_W(SW)) dut_one (
      .clk(clk), .rst_n(rst_n), .policy_i(policy), .thr_state_i(st1),
      .rob_empty_i(emp1), .head_ready_i(rdy1), .head_seq_i(seq[SW-1:0]),
      .grant_used_i(grant), .sel_valid_o(vld1), .sel_tid_o(tid1));

   int tests = 0, fails = 0;
   int order[NT];
   bit done = 0;
   logic [31:0] lcg = 32'h1234_5678;

   function automatic logic [31:0] nxt(input logic [31:0] x);
      return x * 32'd1664525 + 32'd1013904223;
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic bit st_ok(input logic [2:0] s);
      return s == 3'd0 || s == 3'd1 || s == 3'd4;
   endfunction

   function automatic bit is_elig(input int t);
      return st_ok(st[t*3 +: 3]) && !emp[t] && rdy[t];
   endfunction

   // Computes expected outputs; returns expected valid
   task automatic expect_sel(output bit ev, output int et);
      ev = 0; et = 0;
      if (policy == 2'd1) begin
         for (int p = 0; p < NT; p++)
            if (!ev && is_elig(order[p])) begin ev = 1; et = order[p]; end
      end else if (policy != 2'd3) begin
         logic [SW-1:0] b;
         b = '1;
         for (int t = 0; t < NT; t++)
            if (is_elig(t) && (!ev || seq[t*SW +: SW] < b)) begin
               ev = 1; et = t; b = seq[t*SW +: SW];
            end
      end
   endtask

   // Inputs already driven after a falling edge; check, then optionally grant
   task automatic step(input bit g, input string req);
      bit ev; int et;
      #1;
      expect_sel(ev, et);
      check(vld == ev, req, int'(vld), int'(ev));
      check(int'(tid) == et, req, int'(tid), et);
      if (g) begin
         grant = 1'b1;
         @(negedge clk);
         grant = 1'b0;
         if (ev && policy == 2'd1) begin
            int pos;
            pos = 0;
            for (int p = 0; p < NT; p++) if (order[p] == et) pos = p;
            for (int p = 0; p < NT - 1; p++) if (p >= pos) order[p] = order[p+1];
            order[NT-1] = et;
         end
      end else begin
         @(negedge clk);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         tests++;
         $display("FAIL watchdog expired");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      policy = 2'd1; st = '0; emp = '0; rdy = '1; seq = '0; grant = 0;
      st1 = 3'd0; emp1 = 0; rdy1 = 0;
      for (int i = 0; i < NT; i++) order[i] = i;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R8: ascending order after reset, walked by grants (R3, R4)
      for (int k = 0; k < NT; k++) begin
         #1;
         check(vld && int'(tid) == k, "R8 reset order", int'(tid), k);
         @(negedge clk);
         step(1, "R4 rotate");
      end

      // R4: no update without a grant or outside round-robin mode
      st = {3'd0, 3'd0, 3'd0, 3'd0};
      step(0, "R4 hold no grant");
      step(0, "R4 hold no grant");
      policy = 2'd2;
      step(1, "R4 hold oldest mode");
      policy = 2'd1;
      step(0, "R4 after other mode");

      // R3/R4: sweep every eligibility mask, granting each
      for (int m = 0; m < 16; m++) begin
         for (int r = 0; r < 2; r++) begin
            rdy = m[NT-1:0];
            step(1, "R3 mask sweep");
         end
      end

      // R1: each state code on thread 2 alone, all policies
      for (int c = 0; c < 8; c++) begin
         for (int pl = 0; pl < 4; pl++) begin
            policy = pl[1:0];
            st = {3'd2, c[2:0], 3'd3, 3'd3};
            emp = '0; rdy = '1;
            step(0, "R1 state code");
         end
      end

      // R7/R10: nothing eligible, and policy off with all eligible
      st = '0; emp = '1; policy = 2'd2;
      step(0, "R7 none");
      emp = '0; policy = 2'd3;
      step(1, "R10 off");

      // R5 tie: threads 1 and 3 share smallest number
      policy = 2'd2;
      seq = {32'd7, 32'd9, 32'd7, 32'd8};
      step(0, "R5 tie");
      policy = 2'd0;
      step(0, "R6 tie");
      seq = {32'd1, 32'hFFFF_FFFF, 32'h8000_0000, 32'd2};
      step(0, "R5 unsigned");

      // Pseudo-random drift across all policies, grants and states
      for (int it = 0; it < 4000; it++) begin
         lcg = nxt(lcg); policy = lcg[31:30];
         for (int t = 0; t < NT; t++) begin
            lcg = nxt(lcg);
            st[t*3 +: 3] = (lcg[28:27] != 0) ? {1'b0, lcg[26:25]} & 3'b001 : lcg[26:24];
            emp[t] = (lcg[23:21] == 0);
            rdy[t] = (lcg[20:19] != 0);
            seq[t*SW +: SW] = (lcg[18]) ? {29'd0, lcg[17:15]} : lcg;
         end
         lcg = nxt(lcg);
         step(lcg[29], "R3 R5 R6 random");
      end

      // R9: single-thread variant ignores flags and policy
      for (int c = 0; c < 8; c++) begin
         for (int f = 0; f < 16; f++) begin
            st1 = c[2:0]; emp1 = f[0]; rdy1 = f[1]; policy = f[3:2];
            #1;
            check(vld1 == st_ok(c[2:0]), "R9 single", int'(vld1), int'(st_ok(c[2:0])));
            check(tid1 == 1'b0, "R9 single tid", int'(tid1), 0);
            @(negedge clk);
         end
      end

      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule